// File: doc/BRIEF.md
# Vector Register Hazard Tracker

This block guards the vector register file of one SIMD unit against data hazards. It holds two status flags for every physical register. The in-flight flag is raised when an instruction is picked to issue and names that register as a destination. The busy flag is raised while the producing instruction executes. The issue logic offers a group of operands to the check port. Each operand has a register index, a wide flag and a role, source or destination. The block answers combinationally whether the group may issue. When a check is rejected, one of two stall counters is bumped, chosen by the role of the first blocking operand.

An execute request moves a destination from in-flight to busy. A timed execute then releases the register by itself. The delay is a short latency for narrow operands and a longer one for wide operands. An untimed execute is used for non-argument loads, atomics and fences. It keeps the register busy until the memory side names it on the release port. A wide operand covers its own index and the next one. The next index wraps from the last register to register 0. All status changes take effect at the next rising clock edge.

Top module: `vreg_hazard_tracker`

## Requirements
- R1: After reset every busy and in-flight flag is clear, both stall counters read zero, and every check reports ready.
- R2: A reserve request sets the in-flight flag of its destination at the next edge. From then on any operand covering that register blocks ready.
- R3: A wide operand (wide flag 1) covers register idx and register (idx+1) modulo NUM_REGS. This holds for checks, reserves, executes and releases alike. A narrow operand covers only idx.
- R4: chk_ready is 1 exactly when no operand with its chk_op_vld bit set covers a register whose busy or in-flight flag is set. Source and destination operands are treated alike, and slots with chk_op_vld at 0 are ignored.
- R5: A cycle with chk_req at 1 and chk_ready at 0 adds one to exactly one counter at the next edge. The lowest-numbered blocking operand picks the counter: wax_stalls when its chk_op_dst bit is 1 (destination), raw_stalls when it is 0 (source).
- R6: An execute request sets the busy flag and clears the in-flight flag of its destination at the same edge.
- R7: A timed execute (ex_timed 1) of a narrow destination keeps it busy for exactly SP_LAT cycles after the execute edge.
- R8: A timed execute of a wide destination keeps both registers busy for exactly DP_LAT cycles after the execute edge.
- R9: An untimed execute (ex_timed 0) keeps its destination busy until a release. A release is marked by rel_valid and clears the register of every lane whose rel_lane_vld bit is 1, using the shared rel_wide size. A release names at least one lane.
- R10: When an execute sets a register's busy flag in the same cycle that a release or a timer clears it, the flag ends up set. Likewise, a reserve in the same cycle as an execute leaves the in-flight flag set.
- R11: Timers that expire at the same edge all clear their registers at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| chk_req | input | 1 | The offered group is a real issue attempt; a rejection is counted |
| chk_op_vld | input | NUM_OPS | Per operand slot: slot carries a vector operand |
| chk_op_idx | input | NUM_OPS*IDX_W | Per operand slot: physical register index, slot k at bits k*IDX_W |
| chk_op_wide | input | NUM_OPS | Per operand slot: operand wider than 4 bytes |
| chk_op_dst | input | NUM_OPS | Per operand slot: 1 for destination, 0 for source |
| chk_ready | output | 1 | Group may issue |
| rsv_valid | input | 1 | Reserve a destination |
| rsv_idx | input | IDX_W | Reserved register index |
| rsv_wide | input | 1 | Reserved operand is wide |
| ex_valid | input | 1 | Execute a destination |
| ex_idx | input | IDX_W | Executed register index |
| ex_wide | input | 1 | Executed operand is wide |
| ex_timed | input | 1 | 1: release by latency timer; 0: wait for external release |
| rel_valid | input | 1 | External release request |
| rel_lane_vld | input | REL_N | Per release lane: lane names a register |
| rel_idx | input | REL_N*IDX_W | Per release lane: register index, lane k at bits k*IDX_W |
| rel_wide | input | 1 | Operand size of the whole release list is wide |
| raw_stalls | output | CNT_W | Rejections caused by a source operand |
| wax_stalls | output | CNT_W | Rejections caused by a destination operand |

## Verification
The checker assumes that every release request names at least one lane. It also assumes that only one destination is reserved and one executed per cycle, so the timer table sized from DP_LAT never overflows. The directed stimulus drives at most one reserve and one execute per cycle and never raises rel_valid without a lane. Register indices always stay below NUM_REGS. The per-register checks pick cycles where no reserve overlaps an execute, so the flag each one inspects has a single cause.

// File: rtl/vrh_pkg.sv
// Shared types and helpers for the vector register hazard tracker.
// Assumes latencies are small positive integers.
package vrh_pkg;

    typedef enum logic {
        ROLE_SRC = 1'b0,
        ROLE_DST = 1'b1
    } op_role_e;

    // Release latency chosen by operand width.
    function automatic int unsigned pick_latency(input logic wide,
                                                 input int unsigned narrow_lat,
                                                 input int unsigned wide_lat);
        return wide ? wide_lat : narrow_lat;
    endfunction

endpackage

// File: rtl/vrh_footprint.sv
// Turns a register index and width flag into a one-hot or two-hot mask.
// A wide operand also covers the next register, wrapping to 0 at the end.
// Assumes idx < N.
module vrh_footprint #(
    parameter int N  = 32,
    parameter int IW = 5
) (
    input  logic [IW-1:0] idx,
    input  logic          wide,
    output logic [N-1:0]  mask
);
    logic [IW-1:0] nxt;

    // Successor index with wrap-around.
    always_comb nxt = (idx == IW'(N - 1)) ? '0 : idx + 1'b1;

    // Mark the covered registers.
    always_comb begin
        mask      = '0;
        mask[idx] = 1'b1;
        if (wide) mask[nxt] = 1'b1;
    end
endmodule

// File: rtl/vrh_flag_bank.sv
// One status flag per register with set and clear masks applied at the edge.
// A set on the same register as a clear wins. Synchronous active-low reset.
module vrh_flag_bank #(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_mask,
    input  logic [N-1:0] clr_mask,
    output logic [N-1:0] flags
);
    // Update flags; set has priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n) flags <= '0;
        else        flags <= (flags & ~clr_mask) | set_mask;
    end
endmodule

// File: rtl/vrh_hazard_check.sv
// Combinational issue check over a group of operands. Reports ready when
// no valid operand touches a busy or in-flight register, and the role of
// the lowest-numbered blocking operand otherwise.
module vrh_hazard_check
    import vrh_pkg::*;
#(
    parameter int N   = 32,
    parameter int IW  = 5,
    parameter int OPS = 3
) (
    input  logic [N-1:0]      busy,
    input  logic [N-1:0]      inflight,
    input  logic [OPS-1:0]    op_vld,
    input  logic [OPS*IW-1:0] op_idx,
    input  logic [OPS-1:0]    op_wide,
    input  logic [OPS-1:0]    op_dst,
    output logic              ready,
    output op_role_e          blk_role
);
    logic [N-1:0]   op_mask [OPS];
    logic [OPS-1:0] op_blocked;

    for (genvar k = 0; k < OPS; k++) begin : g_op
        vrh_footprint #(.N(N), .IW(IW)) i_fp (
            .idx  (op_idx[k*IW +: IW]),
            .wide (op_wide[k]),
            .mask (op_mask[k])
        );
        // Operand collides with either status flag.
        always_comb op_blocked[k] = op_vld[k] && |(op_mask[k] & (busy | inflight));
    end

    // Ready and the role of the first blocker.
    always_comb begin
        ready    = 1'b1;
        blk_role = ROLE_SRC;
        for (int k = 0; k < OPS; k++) begin
            if (ready && op_blocked[k]) begin
                ready    = 1'b0;
                blk_role = op_dst[k] ? ROLE_DST : ROLE_SRC;
            end
        end
    end
endmodule

// File: rtl/vrh_release_timers.sv
// Table of pending timed releases. Each start takes the lowest free slot,
// loads a countdown chosen by width, and raises its footprint in the expire
// mask in the cycle the count reaches one. Several slots may expire together.
// Assumes at most one start per cycle; DP_LAT+1 slots then never run out.
module vrh_release_timers
    import vrh_pkg::*;
#(
    parameter int N      = 32,
    parameter int IW     = 5,
    parameter int SP_LAT = 4,
    parameter int DP_LAT = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [IW-1:0] start_idx,
    input  logic          start_wide,
    output logic [N-1:0]  expire_mask
);
    localparam int SLOTS = DP_LAT + 1;
    localparam int LW    = $clog2(DP_LAT + 1);

    logic [SLOTS-1:0] slot_vld;
    logic [LW-1:0]    slot_cnt  [SLOTS];
    logic [IW-1:0]    slot_idx  [SLOTS];
    logic             slot_wide [SLOTS];
    logic [N-1:0]     slot_fp   [SLOTS];
    logic [SLOTS-1:0] alloc_hit;
    logic [LW-1:0]    load_cnt;

    // Countdown value for the new entry.
    always_comb load_cnt = LW'(pick_latency(start_wide, SP_LAT, DP_LAT));

    // Lowest free slot.
    always_comb begin
        alloc_hit = '0;
        for (int s = 0; s < SLOTS; s++) begin
            if (!slot_vld[s] && alloc_hit == '0) alloc_hit[s] = 1'b1;
        end
    end

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        vrh_footprint #(.N(N), .IW(IW)) i_fp (
            .idx  (slot_idx[s]),
            .wide (slot_wide[s]),
            .mask (slot_fp[s])
        );

        // Slot state: load on allocation, count down while valid.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_vld[s]  <= 1'b0;
                slot_cnt[s]  <= '0;
                slot_idx[s]  <= '0;
                slot_wide[s] <= 1'b0;
            end else if (start && alloc_hit[s]) begin
                slot_vld[s]  <= 1'b1;
                slot_cnt[s]  <= load_cnt;
                slot_idx[s]  <= start_idx;
                slot_wide[s] <= start_wide;
            end else if (slot_vld[s]) begin
                slot_cnt[s] <= slot_cnt[s] - 1'b1;
                if (slot_cnt[s] == LW'(1)) slot_vld[s] <= 1'b0;
            end
        end
    end

    // Merge footprints of slots expiring this cycle.
    always_comb begin
        expire_mask = '0;
        for (int s = 0; s < SLOTS; s++) begin
            if (slot_vld[s] && slot_cnt[s] == LW'(1)) expire_mask |= slot_fp[s];
        end
    end
endmodule

// File: rtl/vreg_hazard_tracker.sv
// Top of the vector register hazard tracker for one SIMD unit.
// Holds in-flight and busy flags per register, answers issue checks,
// counts rejected checks by blocking role, and releases busy registers
// by timer or external request. Assumes NUM_REGS is even and divisible
// by GRANULE, and at most one reserve and one execute per cycle.
module vreg_hazard_tracker
    import vrh_pkg::*;
#(
    parameter  int NUM_REGS = 32,
    parameter  int GRANULE  = 4,
    parameter  int NUM_OPS  = 3,
    parameter  int REL_N    = 2,
    parameter  int SP_LAT   = 4,
    parameter  int DP_LAT   = 6,
    parameter  int CNT_W    = 16,
    localparam int IDX_W    = $clog2(NUM_REGS)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     chk_req,
    input  logic [NUM_OPS-1:0]       chk_op_vld,
    input  logic [NUM_OPS*IDX_W-1:0] chk_op_idx,
    input  logic [NUM_OPS-1:0]       chk_op_wide,
    input  logic [NUM_OPS-1:0]       chk_op_dst,
    output logic                     chk_ready,
    input  logic                     rsv_valid,
    input  logic [IDX_W-1:0]         rsv_idx,
    input  logic                     rsv_wide,
    input  logic                     ex_valid,
    input  logic [IDX_W-1:0]         ex_idx,
    input  logic                     ex_wide,
    input  logic                     ex_timed,
    input  logic                     rel_valid,
    input  logic [REL_N-1:0]         rel_lane_vld,
    input  logic [REL_N*IDX_W-1:0]   rel_idx,
    input  logic                     rel_wide,
    output logic [CNT_W-1:0]         raw_stalls,
    output logic [CNT_W-1:0]         wax_stalls
);
    if (NUM_REGS % 2 != 0) begin : g_bad_count
        $error("register count must be even");
    end
    if (NUM_REGS % GRANULE != 0) begin : g_bad_granule
        $error("allocation granule must divide the register count");
    end

    logic [NUM_REGS-1:0] busy_q, inflight_q;
    logic [NUM_REGS-1:0] rsv_fp, ex_fp, expire_mask;
    logic [NUM_REGS-1:0] rel_fp [REL_N];
    logic [NUM_REGS-1:0] rel_mask;
    logic [NUM_REGS-1:0] busy_set, busy_clr, infl_set, infl_clr;
    op_role_e            blk_role;

    vrh_footprint #(.N(NUM_REGS), .IW(IDX_W)) i_rsv_fp (
        .idx (rsv_idx), .wide (rsv_wide), .mask (rsv_fp)
    );
    vrh_footprint #(.N(NUM_REGS), .IW(IDX_W)) i_ex_fp (
        .idx (ex_idx), .wide (ex_wide), .mask (ex_fp)
    );

    for (genvar k = 0; k < REL_N; k++) begin : g_rel
        vrh_footprint #(.N(NUM_REGS), .IW(IDX_W)) i_fp (
            .idx  (rel_idx[k*IDX_W +: IDX_W]),
            .wide (rel_wide),
            .mask (rel_fp[k])
        );
    end

    // Union of all lanes named by an external release.
    always_comb begin
        rel_mask = '0;
        for (int k = 0; k < REL_N; k++) begin
            if (rel_valid && rel_lane_vld[k]) rel_mask |= rel_fp[k];
        end
    end

    // Flag update masks.
    always_comb begin
        infl_set = rsv_valid ? rsv_fp : '0;
        infl_clr = ex_valid  ? ex_fp  : '0;
        busy_set = ex_valid  ? ex_fp  : '0;
        busy_clr = expire_mask | rel_mask;
    end

    vrh_flag_bank #(.N(NUM_REGS)) i_inflight (
        .clk (clk), .rst_n (rst_n),
        .set_mask (infl_set), .clr_mask (infl_clr), .flags (inflight_q)
    );
    vrh_flag_bank #(.N(NUM_REGS)) i_busy (
        .clk (clk), .rst_n (rst_n),
        .set_mask (busy_set), .clr_mask (busy_clr), .flags (busy_q)
    );

    vrh_release_timers #(
        .N (NUM_REGS), .IW (IDX_W), .SP_LAT (SP_LAT), .DP_LAT (DP_LAT)
    ) i_timers (
        .clk (clk), .rst_n (rst_n),
        .start (ex_valid && ex_timed),
        .start_idx (ex_idx), .start_wide (ex_wide),
        .expire_mask (expire_mask)
    );

    vrh_hazard_check #(.N(NUM_REGS), .IW(IDX_W), .OPS(NUM_OPS)) i_check (
        .busy (busy_q), .inflight (inflight_q),
        .op_vld (chk_op_vld), .op_idx (chk_op_idx),
        .op_wide (chk_op_wide), .op_dst (chk_op_dst),
        .ready (chk_ready), .blk_role (blk_role)
    );

    // Stall counters, one step per rejected issue attempt.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            raw_stalls <= '0;
            wax_stalls <= '0;
        end else if (chk_req && !chk_ready) begin
            if (blk_role == ROLE_DST) wax_stalls <= wax_stalls + 1'b1;
            else                      raw_stalls <= raw_stalls + 1'b1;
        end
    end
endmodule

// File: rtl/vrh_checker.sv
// Temporal checks for the hazard tracker, bound into the top module.
module vrh_checker #(
    parameter int NUM_REGS = 32,
    parameter int NUM_OPS  = 3,
    parameter int REL_N    = 2,
    parameter int CNT_W    = 16,
    parameter int IDX_W    = 5
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     chk_req,
    input logic [NUM_OPS-1:0]       chk_op_vld,
    input logic [NUM_OPS*IDX_W-1:0] chk_op_idx,
    input logic                     chk_ready,
    input logic                     rsv_valid,
    input logic [IDX_W-1:0]         rsv_idx,
    input logic                     ex_valid,
    input logic [IDX_W-1:0]         ex_idx,
    input logic                     rel_valid,
    input logic [REL_N-1:0]         rel_lane_vld,
    input logic [NUM_REGS-1:0]      busy_q,
    input logic [NUM_REGS-1:0]      inflight_q,
    input logic [CNT_W-1:0]         raw_stalls,
    input logic [CNT_W-1:0]         wax_stalls
);
    // R2
    reserve_marks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsv_valid |=> inflight_q[$past(rsv_idx)]);

    // R6
    exec_sets_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ex_valid |=> busy_q[$past(ex_idx)]);

    // R6
    exec_drops_inflight_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ex_valid && !rsv_valid |=> !inflight_q[$past(ex_idx)]);

    // R4
    ready_means_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chk_ready && chk_op_vld[0] |->
            !busy_q[chk_op_idx[IDX_W-1:0]] && !inflight_q[chk_op_idx[IDX_W-1:0]]);

    // R5
    stall_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chk_req && !chk_ready |=>
            (CNT_W'(raw_stalls - $past(raw_stalls)) + CNT_W'(wax_stalls - $past(wax_stalls))) == CNT_W'(1));

    // R5
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(chk_req && !chk_ready) |=> $stable(raw_stalls) && $stable(wax_stalls));

    // R9
    release_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rel_valid |-> rel_lane_vld != '0);
endmodule

bind vreg_hazard_tracker vrh_checker #(
    .NUM_REGS (NUM_REGS), .NUM_OPS (NUM_OPS), .REL_N (REL_N),
    .CNT_W (CNT_W), .IDX_W (IDX_W)
) i_vrh_checker (
    .clk (clk), .rst_n (rst_n), .chk_req (chk_req),
    .chk_op_vld (chk_op_vld), .chk_op_idx (chk_op_idx), .chk_ready (chk_ready),
    .rsv_valid (rsv_valid), .rsv_idx (rsv_idx),
    .ex_valid (ex_valid), .ex_idx (ex_idx),
    .rel_valid (rel_valid), .rel_lane_vld (rel_lane_vld),
    .busy_q (busy_q), .inflight_q (inflight_q),
    .raw_stalls (raw_stalls), .wax_stalls (wax_stalls)
);

// File: tb/test_vreg_hazard_tracker.sv
// Directed bench: one task per scenario, each checking its own results.
module test_vreg_hazard_tracker;
    localparam int NR  = 32;
    localparam int OPS = 3;
    localparam int RN  = 2;
    localparam int SP  = 4;
    localparam int DP  = 6;
    localparam int CW  = 16;
    localparam int IW  = $clog2(NR);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic chk_req = 1'b0;
    logic [OPS-1:0]    chk_op_vld = '0;
    logic [OPS*IW-1:0] chk_op_idx = '0;
    logic [OPS-1:0]    chk_op_wide = '0;
    logic [OPS-1:0]    chk_op_dst = '0;
    logic chk_ready;
    logic rsv_valid = 1'b0, rsv_wide = 1'b0;
    logic [IW-1:0] rsv_idx = '0;
    logic ex_valid = 1'b0, ex_wide = 1'b0, ex_timed = 1'b0;
    logic [IW-1:0] ex_idx = '0;
    logic rel_valid = 1'b0, rel_wide = 1'b0;
    logic [RN-1:0] rel_lane_vld = '0;
    logic [RN*IW-1:0] rel_idx = '0;
    logic [CW-1:0] raw_stalls, wax_stalls;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    vreg_hazard_tracker #(
        .NUM_REGS (NR), .GRANULE (4), .NUM_OPS (OPS), .REL_N (RN),
        .SP_LAT (SP), .DP_LAT (DP), .CNT_W (CW)
    ) i_vreg_hazard_tracker (
        .clk (clk), .rst_n (rst_n), .chk_req (chk_req),
        .chk_op_vld (chk_op_vld), .chk_op_idx (chk_op_idx),
        .chk_op_wide (chk_op_wide), .chk_op_dst (chk_op_dst),
        .chk_ready (chk_ready),
        .rsv_valid (rsv_valid), .rsv_idx (rsv_idx), .rsv_wide (rsv_wide),
        .ex_valid (ex_valid), .ex_idx (ex_idx), .ex_wide (ex_wide), .ex_timed (ex_timed),
        .rel_valid (rel_valid), .rel_lane_vld (rel_lane_vld),
        .rel_idx (rel_idx), .rel_wide (rel_wide),
        .raw_stalls (raw_stalls), .wax_stalls (wax_stalls)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic set_op(input int k, input int idx, input bit wide, input bit dst);
        chk_op_vld[k]          = 1'b1;
        chk_op_idx[k*IW +: IW] = IW'(idx);
        chk_op_wide[k]         = wide;
        chk_op_dst[k]          = dst;
    endtask

    // Single-operand readiness probe, no counting.
    task automatic probe(input string req, input int idx, input bit wide, input bit exp);
        chk_op_vld = '0;
        set_op(0, idx, wide, 1'b0);
        #1;
        check(req, int'(chk_ready), int'(exp));
        chk_op_vld = '0;
    endtask

    // Issue attempt with the operands already set up, counted at one edge.
    task automatic attempt();
        chk_req = 1'b1;
        tick();
        chk_req = 1'b0;
        chk_op_vld = '0;
    endtask

    task automatic do_rsv(input int idx, input bit wide);
        rsv_valid = 1'b1; rsv_idx = IW'(idx); rsv_wide = wide;
        tick();
        rsv_valid = 1'b0;
    endtask

    task automatic do_exec(input int idx, input bit wide, input bit timed);
        ex_valid = 1'b1; ex_idx = IW'(idx); ex_wide = wide; ex_timed = timed;
        tick();
        ex_valid = 1'b0;
    endtask

    task automatic do_rel(input int i0, input bit v0, input int i1, input bit v1, input bit wide);
        rel_valid = 1'b1; rel_wide = wide;
        rel_lane_vld = {v1, v0};
        rel_idx = {IW'(i1), IW'(i0)};
        tick();
        rel_valid = 1'b0; rel_lane_vld = '0;
    endtask

    task automatic t_reset();
        probe("R1 reg0", 0, 1'b0, 1'b1);
        probe("R1 reg31 wide", 31, 1'b1, 1'b1);
        check("R1 raw", int'(raw_stalls), 0);
        check("R1 wax", int'(wax_stalls), 0);
    endtask

    task automatic t_reserve();
        do_rsv(5, 1'b0);
        probe("R2 reserved blocks", 5, 1'b0, 1'b0);
        probe("R3 narrow leaves neighbour", 6, 1'b0, 1'b1);
        set_op(0, 5, 1'b0, 1'b0);
        attempt();
        check("R5 raw after src block", int'(raw_stalls), 1);
        check("R5 wax unchanged", int'(wax_stalls), 0);
    endtask

    task automatic t_narrow_timer();
        do_exec(5, 1'b0, 1'b1);
        probe("R6 busy after exec", 5, 1'b0, 1'b0);
        repeat (SP - 1) tick();
        probe("R7 still busy last cycle", 5, 1'b0, 1'b0);
        tick();
        probe("R7 R6 free after SP_LAT", 5, 1'b0, 1'b1);
    endtask

    task automatic t_wide_wrap();
        do_rsv(31, 1'b1);
        probe("R3 wrap covers reg0", 0, 1'b0, 1'b0);
        probe("R3 reg30 untouched", 30, 1'b0, 1'b1);
        set_op(0, 0, 1'b0, 1'b1);
        attempt();
        check("R5 wax after dst block", int'(wax_stalls), 1);
        do_exec(31, 1'b1, 1'b1);
        repeat (DP - 1) tick();
        probe("R8 reg0 busy last cycle", 0, 1'b0, 1'b0);
        tick();
        probe("R8 reg0 free after DP_LAT", 0, 1'b0, 1'b1);
        probe("R8 reg31 free after DP_LAT", 31, 1'b0, 1'b1);
    endtask

    task automatic t_first_blocker();
        do_rsv(12, 1'b0);
        do_rsv(13, 1'b0);
        chk_op_vld = '0;
        set_op(0, 1, 1'b0, 1'b0);
        set_op(1, 12, 1'b0, 1'b1);
        set_op(2, 13, 1'b0, 1'b0);
        attempt();
        check("R5 first blocker dst", int'(wax_stalls), 2);
        check("R5 later src ignored", int'(raw_stalls), 1);
        set_op(0, 1, 1'b0, 1'b0);
        set_op(2, 13, 1'b0, 1'b0);
        attempt();
        check("R4 invalid slot skipped", int'(raw_stalls), 2);
        set_op(0, 1, 1'b0, 1'b0);
        set_op(2, 13, 1'b0, 1'b0);
        chk_op_vld[2] = 1'b0;
        #1;
        check("R4 invalid blocked slot ignored", int'(chk_ready), 1);
        chk_op_vld = '0;
    endtask

    task automatic t_untimed();
        do_exec(12, 1'b0, 1'b0);
        do_exec(13, 1'b0, 1'b0);
        repeat (DP + 2) tick();
        probe("R9 untimed stays busy", 12, 1'b0, 1'b0);
        do_rel(12, 1'b1, 13, 1'b0, 1'b0);
        probe("R9 released lane", 12, 1'b0, 1'b1);
        probe("R9 invalid lane ignored", 13, 1'b0, 1'b0);
        do_rel(13, 1'b1, 0, 1'b0, 1'b0);
        probe("R9 second release", 13, 1'b0, 1'b1);
        do_exec(24, 1'b1, 1'b0);
        do_rel(24, 1'b1, 0, 1'b0, 1'b1);
        probe("R3 wide release upper", 25, 1'b0, 1'b1);
    endtask

    task automatic t_priority();
        do_exec(20, 1'b0, 1'b0);
        do_exec(21, 1'b0, 1'b0);
        ex_valid = 1'b1; ex_idx = IW'(20); ex_wide = 1'b0; ex_timed = 1'b0;
        do_rel(20, 1'b1, 21, 1'b1, 1'b0);
        ex_valid = 1'b0;
        probe("R10 set beats release", 20, 1'b0, 1'b0);
        probe("R10 other lane cleared", 21, 1'b0, 1'b1);
        do_rel(20, 1'b1, 0, 1'b0, 1'b0);
        probe("R10 later release frees", 20, 1'b0, 1'b1);
    endtask

    task automatic t_joint_expiry();
        do_exec(2, 1'b1, 1'b1);
        repeat (DP - SP - 1) tick();
        do_exec(8, 1'b0, 1'b1);
        repeat (SP - 1) tick();
        probe("R11 wide still busy", 3, 1'b0, 1'b0);
        probe("R11 narrow still busy", 8, 1'b0, 1'b0);
        tick();
        probe("R11 wide freed together", 2, 1'b1, 1'b1);
        probe("R11 narrow freed together", 8, 1'b0, 1'b1);
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_reserve();
        t_narrow_timer();
        t_wide_wrap();
        t_first_blocker();
        t_untimed();
        t_priority();
        t_joint_expiry();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got 0 expected 1 (run did not complete)");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule